// File: doc/BRIEF.md
# Instruction Fetch Phase Sequencer

This block runs the fetch phase of a character-serial machine whose instructions have no fixed length. Each fetch cycle reads one character from storage at the address held in the instruction address register, then steps that address up by one. The instruction is therefore scanned from its high-order end toward its low-order end. The first cycle is the operation cycle: it loads the opcode character into the operation register. Characters from later cycles are routed by cycle number into two three-character operand address fields and a single modifier character.

An instruction ends when the character read next carries a word mark, because that mark opens the following instruction. Two opcode classes change this. The set-mark class always ends after cycle 6. The unconditional-jump class also ends on a blank character. When fetch ends, a one-cycle done pulse is raised and the sequencer waits for the execute phase to report completion. That report may also redirect the next fetch to a jump target. An instruction that is still running at cycle 9 with no stop condition raises a length error, and fetch halts until reset.

Top module: `ifetch_seq`

## Requirements
- R1: After synchronous reset, `mem_addr` equals the start address (default 1), `fetch_active` is 1, `cycle_cnt` is 1, and `fetch_done`, `prog_skip` and `len_err` are 0.
- R2: The operation cycle (cycle 1) always consumes its character, whatever its word mark. It loads that character into `op_reg` and advances `mem_addr` by one.
- R3: Consumed characters are routed by cycle number. Cycles 2, 3 and 4 load `a_field`, high-order character first, in bits [20:14], [13:7] and [6:0]. Cycles 5, 6 and 7 load `b_field` in the same layout. Cycle 8 loads `mod_char`.
- R4: On any cycle k ≥ 2, except where R5 applies, a character with its word mark set ends fetch without being consumed. `mem_addr` stays on that character and `instr_len` becomes k−1.
- R5: When `op_class` is 1 (set-mark class), cycle 6 consumes its character and ends fetch even if that character carries a word mark. `instr_len` is then 6.
- R6: When `op_class` is 2 (unconditional jump), a character flagged by `rd_blank` on a cycle k ≥ 2 ends fetch without being consumed. For any other class, `rd_blank` has no effect and the character is consumed like any other.
- R7: `fetch_done` is high for exactly the one cycle after the ending cycle, with `fetch_active` low. The sequencer then waits, and the edge that samples `exec_done` high starts a new operation cycle at `mem_addr`.
- R8: `prog_skip` is set when fetch ends by the R5 or R6 stop, or when `exec_done` arrives with `exec_jump` high; in the jump case `mem_addr` is loaded with `jump_addr`. `prog_skip` stays set through the next operation cycle and is cleared from the following cycle onward.
- R9: If cycle 9 meets none of the stop conditions, `len_err` is set and `fetch_active` drops. `fetch_done` is not raised, and `mem_addr` and `len_err` hold until reset.
- R10: The operation cycle clears `a_field`, `b_field` and `mod_char`. Positions that a short instruction does not reach therefore read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_char | input | CW (7) | Character read at `mem_addr` |
| rd_wm | input | 1 | Word mark bit of that character |
| rd_blank | input | 1 | Character is blank |
| op_class | input | 2 | Decoded class of `op_reg`: 0 plain, 1 set-mark, 2 unconditional jump, 3 plain |
| exec_done | input | 1 | Execute phase finished |
| exec_jump | input | 1 | With `exec_done`: fetch next from `jump_addr` |
| jump_addr | input | AW (12) | Jump target address |
| mem_addr | output | AW (12) | Instruction address register, storage read address |
| fetch_active | output | 1 | A fetch cycle is in progress |
| cycle_cnt | output | 4 | Current fetch cycle number (held after the end) |
| instr_len | output | 4 | Characters consumed by the current instruction |
| op_reg | output | CW | Operation register |
| a_field | output | 3·CW | First operand address characters |
| b_field | output | 3·CW | Second operand address characters |
| mod_char | output | CW | Modifier character |
| fetch_done | output | 1 | One-cycle end-of-fetch pulse |
| prog_skip | output | 1 | Sequential instruction access was broken |
| len_err | output | 1 | Instruction exceeded the maximum length |

## Verification
The sharpest overlap is the set-mark forced stop landing on the same cycle as a word-mark stop. The bench provokes it by placing a word mark on the sixth character of a set-mark instruction. It judges the result by whether that character reaches `b_field` and whether `mem_addr` moved past it: the forced stop must win, so the character is consumed. A second overlap is a blank arriving together with a plain class. Here the bench checks that the blank is loaded as data, that fetch continues to the real word mark, and that `prog_skip` stays clear.

// File: rtl/ifetch_pkg.sv
package ifetch_pkg;

    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_WAIT  = 2'd1,
        ST_HALT  = 2'd2
    } fetch_state_e;

    typedef enum logic [1:0] {
        CLS_PLAIN = 2'd0,
        CLS_SETWM = 2'd1,
        CLS_JUMP  = 2'd2,
        CLS_OTHER = 2'd3
    } op_class_e;

    // What the current fetch cycle does with the character on the read bus
    typedef struct packed {
        logic take;     // character belongs to this instruction
        logic finish;   // fetch phase ends at this edge
        logic skip;     // end broke normal sequential access
        logic overrun;  // no stop condition at the last allowed cycle
    } step_t;

    function automatic step_t decide_step(
        input logic      in_fetch,
        input logic      is_op_cycle,
        input logic      is_swm_cycle,
        input logic      is_last_cycle,
        input op_class_e cls,
        input logic      wm,
        input logic      blank
    );
        step_t s;
        s = '0;
        if (in_fetch) begin
            if (is_op_cycle) begin
                s.take = 1'b1;
            end else if (cls == CLS_SETWM && is_swm_cycle) begin
                s.take   = 1'b1;
                s.finish = 1'b1;
                s.skip   = 1'b1;
            end else if (wm) begin
                s.finish = 1'b1;
            end else if (blank && cls == CLS_JUMP) begin
                s.finish = 1'b1;
                s.skip   = 1'b1;
            end else if (is_last_cycle) begin
                s.overrun = 1'b1;
            end else begin
                s.take = 1'b1;
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/ifetch_cycle_ctl.sv
module ifetch_cycle_ctl
    import ifetch_pkg::*;
#(
    parameter int MAX_CYC = 9,
    parameter int SWM_CYC = 6,
    parameter int CYC_W   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_wm,
    input  logic             rd_blank,
    input  op_class_e        cls,
    input  logic             exec_done,
    input  logic             exec_jump,
    output fetch_state_e     state,
    output logic [CYC_W-1:0] cyc,
    output logic [CYC_W-1:0] len,
    output step_t            step,
    output logic             op_cycle,
    output logic             jump_take,
    output logic             done_pulse,
    output logic             skip_flag,
    output logic             overrun_flag
);
    localparam logic [CYC_W-1:0] CYC_FIRST = CYC_W'(1);
    localparam logic [CYC_W-1:0] CYC_LAST  = CYC_W'(MAX_CYC);
    localparam logic [CYC_W-1:0] CYC_SWM   = CYC_W'(SWM_CYC);

    fetch_state_e     state_q;
    logic [CYC_W-1:0] cyc_q;
    logic [CYC_W-1:0] len_q;
    logic             done_q;
    logic             skip_q;
    logic             ovr_q;

    always_comb begin
        op_cycle  = (state_q == ST_FETCH) && (cyc_q == CYC_FIRST);
        step      = decide_step(state_q == ST_FETCH, cyc_q == CYC_FIRST,
                                cyc_q == CYC_SWM, cyc_q == CYC_LAST,
                                cls, rd_wm, rd_blank);
        jump_take = (state_q == ST_WAIT) && exec_done && exec_jump;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FETCH;
            cyc_q   <= CYC_FIRST;
            len_q   <= '0;
            done_q  <= 1'b0;
            skip_q  <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_FETCH: begin
                    if (op_cycle) skip_q <= 1'b0;
                    if (step.skip) skip_q <= 1'b1;
                    if (step.take) len_q <= cyc_q;
                    if (step.finish) begin
                        state_q <= ST_WAIT;
                        done_q  <= 1'b1;
                    end else if (step.overrun) begin
                        state_q <= ST_HALT;
                        ovr_q   <= 1'b1;
                    end else begin
                        cyc_q <= cyc_q + CYC_W'(1);
                    end
                end
                ST_WAIT: begin
                    if (exec_done) begin
                        state_q <= ST_FETCH;
                        cyc_q   <= CYC_FIRST;
                        if (exec_jump) skip_q <= 1'b1;
                    end
                end
                default: begin
                    state_q <= ST_HALT;
                end
            endcase
        end
    end

    assign state        = state_q;
    assign cyc          = cyc_q;
    assign len          = len_q;
    assign done_pulse   = done_q;
    assign skip_flag    = skip_q;
    assign overrun_flag = ovr_q;

endmodule

// File: rtl/ifetch_iar.sv
module ifetch_iar #(
    parameter int AW         = 12,
    parameter int START_ADDR = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          advance,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= AW'(START_ADDR);
        end else if (load) begin
            addr_q <= load_addr;
        end else if (advance) begin
            addr_q <= addr_q + AW'(1);
        end
    end

    assign addr = addr_q;

endmodule

// File: rtl/ifetch_capture.sv
module ifetch_capture #(
    parameter int CW         = 7,
    parameter int CYC_W      = 4,
    parameter int ADDR_CHARS = 3,
    parameter int A_FIRST    = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     op_cycle,
    input  logic                     take,
    input  logic [CYC_W-1:0]         cyc,
    input  logic [CW-1:0]            rd_char,
    output logic [CW-1:0]            op_q,
    output logic [ADDR_CHARS*CW-1:0] a_q,
    output logic [ADDR_CHARS*CW-1:0] b_q,
    output logic [CW-1:0]            mod_q
);
    localparam int B_FIRST = A_FIRST + ADDR_CHARS;
    localparam int MOD_CYC = B_FIRST + ADDR_CHARS;
    localparam logic [CYC_W-1:0] MOD_SLOT = CYC_W'(MOD_CYC);

    logic [CW-1:0] op_r;
    logic [CW-1:0] mod_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_r  <= '0;
            mod_r <= '0;
        end else if (op_cycle) begin
            op_r  <= rd_char;
            mod_r <= '0;
        end else if (take && cyc == MOD_SLOT) begin
            mod_r <= rd_char;
        end
    end

    // One register per operand character; the first fetched sits high
    for (genvar g = 0; g < ADDR_CHARS; g++) begin : g_slot
        localparam logic [CYC_W-1:0] A_SLOT = CYC_W'(A_FIRST + g);
        localparam logic [CYC_W-1:0] B_SLOT = CYC_W'(B_FIRST + g);
        localparam int HI = (ADDR_CHARS - g) * CW - 1;
        localparam int LO = (ADDR_CHARS - 1 - g) * CW;
        logic [CW-1:0] a_r;
        logic [CW-1:0] b_r;

        always_ff @(posedge clk) begin
            if (rst || op_cycle) begin
                a_r <= '0;
                b_r <= '0;
            end else if (take) begin
                if (cyc == A_SLOT) a_r <= rd_char;
                if (cyc == B_SLOT) b_r <= rd_char;
            end
        end

        assign a_q[HI:LO] = a_r;
        assign b_q[HI:LO] = b_r;
    end

    assign op_q  = op_r;
    assign mod_q = mod_r;

endmodule

// File: rtl/ifetch_seq.sv
module ifetch_seq
    import ifetch_pkg::*;
#(
    parameter int AW         = 12,
    parameter int CW         = 7,
    parameter int START_ADDR = 1,
    parameter int ADDR_CHARS = 3,
    parameter int MAX_CYC    = 2 * ADDR_CHARS + 3,
    parameter int SWM_CYC    = 6
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [CW-1:0]                  rd_char,
    input  logic                           rd_wm,
    input  logic                           rd_blank,
    input  logic [1:0]                     op_class,
    input  logic                           exec_done,
    input  logic                           exec_jump,
    input  logic [AW-1:0]                  jump_addr,
    output logic [AW-1:0]                  mem_addr,
    output logic                           fetch_active,
    output logic [$clog2(MAX_CYC+1)-1:0]   cycle_cnt,
    output logic [$clog2(MAX_CYC+1)-1:0]   instr_len,
    output logic [CW-1:0]                  op_reg,
    output logic [ADDR_CHARS*CW-1:0]       a_field,
    output logic [ADDR_CHARS*CW-1:0]       b_field,
    output logic [CW-1:0]                  mod_char,
    output logic                           fetch_done,
    output logic                           prog_skip,
    output logic                           len_err
);
    localparam int CYC_W = $clog2(MAX_CYC + 1);

    fetch_state_e     state;
    step_t            step;
    logic             op_cycle;
    logic             jump_take;
    op_class_e        cls;

    assign cls = op_class_e'(op_class);

    ifetch_cycle_ctl #(
        .MAX_CYC (MAX_CYC),
        .SWM_CYC (SWM_CYC),
        .CYC_W   (CYC_W)
    ) u_ctl (
        .clk          (clk),
        .rst          (rst),
        .rd_wm        (rd_wm),
        .rd_blank     (rd_blank),
        .cls          (cls),
        .exec_done    (exec_done),
        .exec_jump    (exec_jump),
        .state        (state),
        .cyc          (cycle_cnt),
        .len          (instr_len),
        .step         (step),
        .op_cycle     (op_cycle),
        .jump_take    (jump_take),
        .done_pulse   (fetch_done),
        .skip_flag    (prog_skip),
        .overrun_flag (len_err)
    );

    ifetch_iar #(
        .AW         (AW),
        .START_ADDR (START_ADDR)
    ) u_iar (
        .clk       (clk),
        .rst       (rst),
        .advance   (step.take),
        .load      (jump_take),
        .load_addr (jump_addr),
        .addr      (mem_addr)
    );

    ifetch_capture #(
        .CW         (CW),
        .CYC_W      (CYC_W),
        .ADDR_CHARS (ADDR_CHARS),
        .A_FIRST    (2)
    ) u_cap (
        .clk      (clk),
        .rst      (rst),
        .op_cycle (op_cycle),
        .take     (step.take),
        .cyc      (cycle_cnt),
        .rd_char  (rd_char),
        .op_q     (op_reg),
        .a_q      (a_field),
        .b_q      (b_field),
        .mod_q    (mod_char)
    );

    assign fetch_active = (state == ST_FETCH);

endmodule

// File: rtl/ifetch_seq_chk.sv
module ifetch_seq_chk #(
    parameter int AW      = 12,
    parameter int CW      = 7,
    parameter int MAX_CYC = 9,
    parameter int SWM_CYC = 6
) (
    input logic                         clk,
    input logic                         rst,
    input logic [CW-1:0]                rd_char,
    input logic                         rd_wm,
    input logic [1:0]                   op_class,
    input logic [AW-1:0]                mem_addr,
    input logic                         fetch_active,
    input logic [$clog2(MAX_CYC+1)-1:0] cycle_cnt,
    input logic [CW-1:0]                op_reg,
    input logic                         fetch_done,
    input logic                         prog_skip,
    input logic                         len_err
);
    localparam int CYC_W = $clog2(MAX_CYC + 1);
    localparam logic [CYC_W-1:0] C_ONE = CYC_W'(1);
    localparam logic [CYC_W-1:0] C_SWM = CYC_W'(SWM_CYC);

    p_op_load_r2: assert property (@(posedge clk) disable iff (rst)
        fetch_active && cycle_cnt == C_ONE |=> op_reg == $past(rd_char));

    p_wm_stop_r4: assert property (@(posedge clk) disable iff (rst)
        fetch_active && cycle_cnt != C_ONE && rd_wm
        && !(op_class == 2'd1 && cycle_cnt == C_SWM)
        |=> fetch_done && mem_addr == $past(mem_addr));

    p_forced_stop_r5: assert property (@(posedge clk) disable iff (rst)
        fetch_active && op_class == 2'd1 && cycle_cnt == C_SWM
        |=> fetch_done && mem_addr == $past(mem_addr) + AW'(1));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        fetch_done |-> !fetch_active ##1 !fetch_done);

    p_skip_clear_r8: assert property (@(posedge clk) disable iff (rst)
        fetch_active && cycle_cnt == C_ONE |=> !prog_skip);

    p_halt_hold_r9: assert property (@(posedge clk) disable iff (rst)
        len_err |=> len_err && $stable(mem_addr) && !fetch_active && !fetch_done);

endmodule

bind ifetch_seq ifetch_seq_chk #(
    .AW      (AW),
    .CW      (CW),
    .MAX_CYC (MAX_CYC),
    .SWM_CYC (SWM_CYC)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .rd_char      (rd_char),
    .rd_wm        (rd_wm),
    .op_class     (op_class),
    .mem_addr     (mem_addr),
    .fetch_active (fetch_active),
    .cycle_cnt    (cycle_cnt),
    .op_reg       (op_reg),
    .fetch_done   (fetch_done),
    .prog_skip    (prog_skip),
    .len_err      (len_err)
);

// File: tb/ifetch_seq_bench.sv
module ifetch_seq_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  rd_char;
    logic        rd_wm;
    logic        rd_blank;
    logic [1:0]  op_class = 2'd0;
    logic        exec_done = 1'b0;
    logic        exec_jump = 1'b0;
    logic [11:0] jump_addr = '0;
    logic [11:0] mem_addr;
    logic        fetch_active;
    logic [3:0]  cycle_cnt;
    logic [3:0]  instr_len;
    logic [6:0]  op_reg;
    logic [20:0] a_field;
    logic [20:0] b_field;
    logic [6:0]  mod_char;
    logic        fetch_done;
    logic        prog_skip;
    logic        len_err;

    logic [6:0] m_chr [0:127];
    logic       m_wm  [0:127];
    logic       m_blk [0:127];

    int n_chk  = 0;
    int n_fail = 0;
    bit over   = 0;

    always #5 clk = ~clk;

    assign rd_char  = m_chr[mem_addr[6:0]];
    assign rd_wm    = m_wm[mem_addr[6:0]];
    assign rd_blank = m_blk[mem_addr[6:0]];

    ifetch_seq u_ifetch_seq (
        .clk(clk), .rst(rst), .rd_char(rd_char), .rd_wm(rd_wm),
        .rd_blank(rd_blank), .op_class(op_class), .exec_done(exec_done),
        .exec_jump(exec_jump), .jump_addr(jump_addr), .mem_addr(mem_addr),
        .fetch_active(fetch_active), .cycle_cnt(cycle_cnt),
        .instr_len(instr_len), .op_reg(op_reg), .a_field(a_field),
        .b_field(b_field), .mod_char(mod_char), .fetch_done(fetch_done),
        .prog_skip(prog_skip), .len_err(len_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 128; i++) begin
            m_chr[i] = 7'h00; m_wm[i] = 1'b0; m_blk[i] = 1'b0;
        end
    endtask

    task automatic put(input int a, input logic [6:0] c, input logic w, input logic b);
        m_chr[a] = c; m_wm[a] = w; m_blk[a] = b;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 20; i++) begin
            if (fetch_done || len_err) break;
            @(negedge clk);
        end
    endtask

    task automatic pulse_exec(input logic jmp, input logic [11:0] tgt);
        exec_done = 1'b1; exec_jump = jmp; jump_addr = tgt;
        @(negedge clk);
        exec_done = 1'b0; exec_jump = 1'b0;
    endtask

    task automatic t_reset();
        clear_mem();
        put(1, 7'h11, 1, 0); put(2, 7'h00, 1, 0);
        do_reset();
        chk("R1 addr", 32'(mem_addr), 32'd1);
        chk("R1 active", 32'(fetch_active), 32'd1);
        chk("R1 cycle", 32'(cycle_cnt), 32'd1);
        chk("R1 flags", {29'd0, fetch_done, prog_skip, len_err}, 32'd0);
    endtask

    task automatic t_full_then_short();
        clear_mem(); op_class = 2'd0;
        put(1, 7'h11, 1, 0);
        put(2, 7'h21, 0, 0); put(3, 7'h22, 0, 0); put(4, 7'h23, 0, 0);
        put(5, 7'h31, 0, 0); put(6, 7'h32, 0, 0); put(7, 7'h33, 0, 0);
        put(8, 7'h12, 1, 0); put(9, 7'h41, 0, 0); put(10, 7'h13, 1, 0);
        do_reset();
        wait_end();
        chk("R2 op_reg", 32'(op_reg), 32'h11);
        chk("R3 a_field", 32'(a_field), 32'({7'h21, 7'h22, 7'h23}));
        chk("R3 b_field", 32'(b_field), 32'({7'h31, 7'h32, 7'h33}));
        chk("R4 len", 32'(instr_len), 32'd7);
        chk("R4 addr on mark", 32'(mem_addr), 32'd8);
        chk("R7 done pulse", {30'd0, fetch_done, fetch_active}, 32'b10);
        @(negedge clk);
        chk("R7 single pulse", {30'd0, fetch_done, fetch_active}, 32'b00);
        pulse_exec(1'b0, '0);
        chk("R7 restart", {28'd0, fetch_active, cycle_cnt[2:0]}, 32'b1001);
        wait_end();
        chk("R10 a cleared", 32'(a_field), 32'({7'h41, 7'h00, 7'h00}));
        chk("R10 b cleared", 32'(b_field), 32'd0);
        chk("R4 short len", 32'(instr_len), 32'd2);
    endtask

    task automatic t_modifier();
        clear_mem(); op_class = 2'd0;
        put(1, 7'h14, 1, 0);
        for (int i = 2; i <= 7; i++) put(i, 7'(7'h20 + i), 0, 0);
        put(8, 7'h55, 0, 0); put(9, 7'h15, 1, 0);
        do_reset();
        wait_end();
        chk("R3 mod_char", 32'(mod_char), 32'h55);
        chk("R4 len at cycle 9 mark", 32'(instr_len), 32'd8);
        chk("R9 no error", 32'(len_err), 32'd0);
    endtask

    task automatic t_setwm_overlap();
        clear_mem(); op_class = 2'd1;
        put(1, 7'h16, 1, 0);
        put(2, 7'h21, 0, 0); put(3, 7'h22, 0, 0); put(4, 7'h23, 0, 0);
        put(5, 7'h31, 0, 0); put(6, 7'h32, 1, 0);
        put(7, 7'h17, 1, 0); put(8, 7'h00, 1, 0);
        do_reset();
        wait_end();
        chk("R5 len", 32'(instr_len), 32'd6);
        chk("R5 char6 consumed", 32'(b_field), 32'({7'h31, 7'h32, 7'h00}));
        chk("R5 addr past", 32'(mem_addr), 32'd7);
        chk("R8 skip on forced", 32'(prog_skip), 32'd1);
        op_class = 2'd0;
        pulse_exec(1'b0, '0);
        chk("R8 skip during op cycle", 32'(prog_skip), 32'd1);
        @(negedge clk);
        chk("R8 skip cleared", 32'(prog_skip), 32'd0);
    endtask

    task automatic t_jump_blank();
        clear_mem(); op_class = 2'd2;
        put(1, 7'h18, 1, 0);
        put(2, 7'h21, 0, 0); put(3, 7'h22, 0, 0); put(4, 7'h23, 0, 0);
        put(5, 7'h00, 0, 1);
        do_reset();
        wait_end();
        chk("R6 blank stop len", 32'(instr_len), 32'd4);
        chk("R6 blank addr", 32'(mem_addr), 32'd5);
        chk("R8 skip on blank", 32'(prog_skip), 32'd1);
    endtask

    task automatic t_plain_blank_and_jump();
        clear_mem(); op_class = 2'd0;
        put(1, 7'h19, 1, 0);
        put(2, 7'h21, 0, 0); put(3, 7'h22, 0, 0); put(4, 7'h00, 0, 1);
        put(5, 7'h31, 0, 0); put(6, 7'h1a, 1, 0);
        put(64, 7'h1b, 1, 0); put(65, 7'h1c, 1, 0);
        do_reset();
        wait_end();
        chk("R6 blank ignored len", 32'(instr_len), 32'd5);
        chk("R6 blank as data", 32'(a_field), 32'({7'h21, 7'h22, 7'h00}));
        chk("R6 no skip", 32'(prog_skip), 32'd0);
        pulse_exec(1'b1, 12'h040);
        chk("R8 jump addr", 32'(mem_addr), 32'h40);
        chk("R8 jump skip", {30'd0, prog_skip, fetch_active}, 32'b11);
        @(negedge clk);
        chk("R8 jump skip cleared", 32'(prog_skip), 32'd0);
        chk("R2 addr step", 32'(mem_addr), 32'h41);
    endtask

    task automatic t_overrun();
        clear_mem(); op_class = 2'd0;
        put(1, 7'h1d, 1, 0);
        for (int i = 2; i <= 12; i++) put(i, 7'(7'h30 + i), 0, 0);
        do_reset();
        wait_end();
        chk("R9 len_err", 32'(len_err), 32'd1);
        chk("R9 no done", 32'(fetch_done), 32'd0);
        chk("R9 addr", 32'(mem_addr), 32'd9);
        repeat (3) @(negedge clk);
        chk("R9 hold", {19'd0, len_err, fetch_active, mem_addr[10:0]}, {19'd0, 1'b1, 1'b0, 11'd9});
    endtask

    initial begin
        clear_mem();
        t_reset();
        t_full_then_short();
        t_modifier();
        t_setwm_overlap();
        t_jump_blank();
        t_plain_blank_and_jump();
        t_overrun();
        if (!over) begin
            over = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!over) begin
            over = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule